// File: doc/BRIEF.md
# Two-Phase Alternating PWM Steering Logic

This block is the digital control core of a two-phase, peak-current-mode buck controller. A single oscillator event, a one-clock pulse issued when the timing ramp peaks, turns on one of two logic-level PWM outputs. The phase that turns on alternates with every event, so each output runs at half the oscillator rate. Its duty cycle can never exceed one half, because each output is high for at most one period out of two.

An on-phase ends in one of two ways. Either the current-comparator trip input clears it, or the next oscillator event hands conduction over to the other phase within a single clock. The two outputs are never high together. A programmable blanking count masks the trip input for a number of clocks after each turn-on, which rejects the leading-edge current spike. A status output tells which phase the next event will start. The oscillator, the error amplifier, the comparator and the gate drivers are outside the block.

Top module: `pwm_phase_steer`

## Requirements
- R1: While `rst` is high at a clock edge, both `pwm_a` and `pwm_b` go low and `next_phase` goes to 0. The encoding is 0 for phase A next and 1 for phase B next.
- R2: `osc_evt` high at an edge drives the output chosen by `next_phase` high after that edge and drives the other output low. Value 0 selects `pwm_a` and value 1 selects `pwm_b`.
- R3: Every `osc_evt` inverts `next_phase`. After reset, the first event turns on `pwm_a`, the second turns on `pwm_b`, and so on alternately.
- R4: A trip that is not masked, with no `osc_evt` in the same cycle, clears the high output after that edge. The output stays low until the next event.
- R5: `pwm_a` and `pwm_b` are never high in the same cycle.
- R6: Without a trip, an output stays high until the next event. At that event it falls in the same clock that the other output rises.
- R7: A trip while both outputs are low has no effect. Both outputs stay low and `next_phase` keeps its value.
- R8: After each event, trips at the next `blank_len` edges are ignored. With `blank_len` = 0, no trip is ignored.
- R9: When `osc_evt` and `cs_trip` are high in the same cycle, the event wins and the newly selected output turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_evt | input | 1 | One-clock pulse at the ramp peak |
| cs_trip | input | 1 | Current-comparator trip |
| blank_len | input | BLANK_W | Number of clocks that trips are masked after each turn-on |
| pwm_a | output | 1 | Phase A PWM output |
| pwm_b | output | 1 | Phase B PWM output |
| next_phase | output | 1 | Phase the next event starts (0 = A, 1 = B) |

## Verification
The bench drives trips in the same cycle as an event, which a design giving priority to the trip would answer by leaving both outputs low. It issues trips while both outputs are idle, which a design that let the trip feed the selector would answer by shifting the alternation. It probes the blanking window at its last masked clock and at its first open clock; an off-by-one counter would clear the output one clock early or one clock late. It also runs long sequences of events with no trips, which would show any handover that leaves an overlap cycle.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_t;

    localparam int unsigned NUM_PHASES = 2;

    typedef logic [NUM_PHASES-1:0] pwm_vec_t;

    function automatic phase_t phase_flip(phase_t p);
        return (p == PH_A) ? PH_B : PH_A;
    endfunction

    function automatic logic phase_match(phase_t p, int unsigned idx);
        return (int'(p) == idx);
    endfunction

endpackage

// File: rtl/phase_selector.sv
module phase_selector
    import pwm_steer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   osc_evt,
    output phase_t sel_q
);

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= PH_A;
        else if (osc_evt)
            sel_q <= phase_flip(sel_q);
    end

    // R3: every event inverts the selection
    p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        osc_evt |=> (sel_q != $past(sel_q)));

    // R7: without an event the selection holds, trips included
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !osc_evt |=> $stable(sel_q));

endmodule

// File: rtl/trip_blanker.sv
module trip_blanker #(
    parameter int unsigned BLANK_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BLANK_W-1:0] len,
    input  logic               trip_in,
    output logic               trip_ok
);

    logic [BLANK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign trip_ok = trip_in && (cnt_q == '0);

    // R8: a nonzero window masks the trip on the first edge after start
    p_blank_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (start && (len != '0)) |=> !trip_ok);

    // R8: a zero window passes the trip straight through
    p_blank_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (start && (len == '0)) |=> (trip_ok == trip_in));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_steer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     osc_evt,
    input  phase_t   fire_ph,
    input  logic     trip_ok,
    output pwm_vec_t pwm_q
);

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
        always_ff @(posedge clk) begin
            if (rst)
                pwm_q[i] <= 1'b0;
            else if (osc_evt)
                pwm_q[i] <= phase_match(fire_ph, i);
            else if (trip_ok)
                pwm_q[i] <= 1'b0;
        end
    end

    // R5: the outputs never overlap
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(pwm_q) <= 1);

    // R2: after an event exactly one output is high
    p_event_on_r2: assert property (@(posedge clk) disable iff (rst)
        osc_evt |=> $onehot0(pwm_q) && (pwm_q != '0));

    // R4: an unmasked trip with no event clears the outputs
    p_trip_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (!osc_evt && trip_ok) |=> (pwm_q == '0));

    // R7: idle outputs stay idle until an event
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!osc_evt && (pwm_q == '0)) |=> (pwm_q == '0));

    // R6: without event or trip an output holds its level
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!osc_evt && !trip_ok) |=> $stable(pwm_q));

endmodule

// File: rtl/pwm_phase_steer.sv
module pwm_phase_steer
    import pwm_steer_pkg::*;
#(
    parameter int unsigned BLANK_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               osc_evt,
    input  logic               cs_trip,
    input  logic [BLANK_W-1:0] blank_len,
    output logic               pwm_a,
    output logic               pwm_b,
    output logic               next_phase
);

    phase_t   sel;
    logic     trip_ok;
    pwm_vec_t pwm_q;

    phase_selector u_sel (
        .clk     (clk),
        .rst     (rst),
        .osc_evt (osc_evt),
        .sel_q   (sel)
    );

    trip_blanker #(.BLANK_W(BLANK_W)) u_blank (
        .clk     (clk),
        .rst     (rst),
        .start   (osc_evt),
        .len     (blank_len),
        .trip_in (cs_trip),
        .trip_ok (trip_ok)
    );

    pwm_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .osc_evt (osc_evt),
        .fire_ph (sel),
        .trip_ok (trip_ok),
        .pwm_q   (pwm_q)
    );

    assign pwm_a      = pwm_q[int'(PH_A)];
    assign pwm_b      = pwm_q[int'(PH_B)];
    assign next_phase = logic'(sel);

    // R9: an event beats a coincident trip
    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (osc_evt && cs_trip) |=> (pwm_a || pwm_b));

    // R1: reset leaves the block idle with phase A next
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!pwm_a && !pwm_b && !next_phase));

endmodule

// File: tb/pwm_phase_steer_tb.sv
module pwm_phase_steer_tb;

    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          osc_evt;
    logic          cs_trip;
    logic [BW-1:0] blank_len;
    logic          pwm_a, pwm_b, next_phase;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_a, m_b, m_sel, m_blk;

    always #4 clk = ~clk;

    pwm_phase_steer #(.BLANK_W(BW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .osc_evt    (osc_evt),
        .cs_trip    (cs_trip),
        .blank_len  (blank_len),
        .pwm_a      (pwm_a),
        .pwm_b      (pwm_b),
        .next_phase (next_phase)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // apply one cycle of stimulus at a negedge, advance the model, compare at the next negedge
    task automatic step(bit r, bit o, bit t, string tag);
        rst = r; osc_evt = o; cs_trip = t;
        if (r) begin
            m_a = 0; m_b = 0; m_sel = 0; m_blk = 0;
        end else if (o) begin
            m_a = (m_sel == 0); m_b = (m_sel == 1);
            m_sel = 1 - m_sel;
            m_blk = int'(blank_len);
        end else begin
            if (t && m_blk == 0) begin m_a = 0; m_b = 0; end
            if (m_blk > 0) m_blk--;
        end
        @(negedge clk);
        check({tag, " pwm_a"}, int'(pwm_a), m_a);
        check({tag, " pwm_b"}, int'(pwm_b), m_b);
        check({tag, " next_phase"}, int'(next_phase), m_sel);
        check("R5 overlap", int'(pwm_a && pwm_b), 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; osc_evt = 1'b0; cs_trip = 1'b0; blank_len = '0;
        m_a = 0; m_b = 0; m_sel = 0; m_blk = 0;
        @(negedge clk);
        step(1, 0, 0, "R1");
        step(1, 0, 0, "R1");

        // R3/R2/R6: alternation with no trips, handover in one clock
        for (int k = 0; k < 6; k++) begin
            step(0, 1, 0, "R3");
            step(0, 0, 0, "R6");
            step(0, 0, 0, "R6");
        end

        // R4: trip mid on-phase, then stays low
        step(0, 1, 0, "R2");
        step(0, 0, 0, "R6");
        step(0, 0, 1, "R4");
        step(0, 0, 0, "R4");
        step(0, 0, 0, "R4");

        // R7: trips while idle change nothing
        step(0, 0, 1, "R7");
        step(0, 0, 1, "R7");
        step(0, 1, 0, "R7");

        // R9: event and trip together
        step(0, 1, 1, "R9");
        step(0, 0, 0, "R9");

        // R8: blanking window of 3, probe last masked and first open edge
        blank_len = 4'd3;
        step(0, 1, 0, "R8");
        step(0, 0, 1, "R8");
        step(0, 0, 1, "R8");
        step(0, 0, 1, "R8");
        step(0, 0, 1, "R8");
        step(0, 0, 0, "R8");
        // R8: trip after a gap is honoured only after the window
        step(0, 1, 0, "R8");
        step(0, 0, 0, "R8");
        step(0, 0, 0, "R8");
        step(0, 0, 1, "R8");
        step(0, 0, 1, "R8");
        // R8: zero window passes trip on first edge
        blank_len = 4'd0;
        step(0, 1, 0, "R8");
        step(0, 0, 1, "R8");

        // R5: pseudo-random mix
        for (int k = 0; k < 400; k++) begin
            bit o, t;
            o = ($urandom_range(0, 3) == 0);
            t = ($urandom_range(0, 2) == 0);
            if ((k % 50) == 0) blank_len = BW'($urandom_range(0, 5));
            step(0, o, t, "R5");
        end

        // R1: reset in mid-operation
        step(0, 1, 0, "R1");
        step(1, 0, 0, "R1");
        step(0, 1, 0, "R3");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule